// File: doc/BRIEF.md
# Scrambled Memory Write-Hold Pipeline

This block puts a single-port, scrambled word memory behind a request/grant bus port. Each stored word has 39 bits: 32 data bits and 7 integrity bits. The whole 39-bit word is XORed with an address-dependent keystream on the way in and again on the way out. The keystream unit registers its middle stage, so the keystream for an accepted request is ready one cycle after acceptance. Reads use it in that cycle to descramble the memory output. Writes are therefore deferred by one cycle, and one keystream path serves both reads and writes.

A deferred write can meet a read that needs the memory port in the same cycle. Two holding registers cover this case. A plain holding register keeps the pending write's address and unscrambled word, and it feeds any read to that address. A scrambled holding register keeps the encrypted word until a cycle with a free port, which lets reads and writes alternate at one request per cycle. A write with a partial byte mask reads the old word, merges the enabled bytes, recomputes the integrity bits and writes the result back. The grant is held low for the two cycles after such a write is accepted.

Top module: `scram_mem_pipe`

## Requirements
- R1: Out of a partial-write sequence, `gnt_o` is high, and a full-mask write (`be_i == 4'hF`) never lowers it, so back-to-back full writes are accepted every cycle.
- R2: A read accepted in cycle n gives `rvalid_o` high in cycle n+1, carrying the latest data written to that address. This holds for every byte mask.
- R3: Alternating reads and writes, to the same or to different addresses, are each accepted in consecutive cycles and return correct data.
- R4: A read accepted in the cycle right after a write to the same address returns the newly written data.
- R5: A write followed by one or more reads to other addresses is still committed. A later read of its address returns the written data.
- R6: A write whose mask is not all ones replaces only byte k (bits 8k+7..8k) for each set bit k of `be_i`. The other bytes keep their previous value, and a mask of zero leaves the word unchanged.
- R7: After a partial-mask write is accepted in cycle n, `gnt_o` is low in cycles n+1 and n+2 and high again in cycle n+3.
- R8: `rintg_o` carries the stored integrity bits of the returned word. Bit i is the XOR of the data bits j with j mod 7 == i, and it is recomputed after every merge.
- R9: While `rst_i` is high and right after it falls, `gnt_o` is 1 and `rvalid_o` is 0.
- R10: A write produces no response: `rvalid_o` is low in the cycle after a write is accepted.
- R11: A request made while `gnt_o` is low is ignored and does not change memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Word address |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data |
| key_i | input | 64 | Scrambling key (held stable) |
| nonce_i | input | 64 | Scrambling nonce (held stable) |
| gnt_o | output | 1 | Request accepted when high with req_i |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | 32 | Read data |
| rintg_o | output | 7 | Integrity bits of the read word |

## Verification
A deferred write commit can fall in the same cycle as a read that needs the memory port, or as a read of the address still waiting to be written. The bench provokes both. It runs write/read pairs to one address, writes followed by runs of reads elsewhere, and partial writes that land directly behind a pending full write. It also drives random traffic over four addresses. A behavioural reference memory, updated in request order, supplies the expected read data and integrity bits. Every cycle the bench compares grant, response valid, data and integrity against that memory.

// File: rtl/scram_mem_pkg.sv
package scram_mem_pkg;
    localparam int DW = 32;
    localparam int IW = 7;
    localparam int WW = DW + IW;
    localparam int KW = 64;

    typedef logic [WW-1:0] word_t;

    typedef enum logic [1:0] {HOLD_EMPTY, HOLD_PLAIN, HOLD_SCRAM} hold_st_e;
    typedef enum logic [1:0] {RMW_IDLE, RMW_MERGE, RMW_WRITE} rmw_st_e;

    function automatic word_t encode_word(input logic [DW-1:0] d);
        logic [IW-1:0] p;
        for (int i = 0; i < IW; i++) begin
            p[i] = 1'b0;
            for (int j = i; j < DW; j += IW) p[i] = p[i] ^ d[j];
        end
        return {p, d};
    endfunction

    function automatic logic [KW-1:0] ks_mix1(input logic [KW-1:0] key,
                                              input logic [KW-1:0] nonce,
                                              input logic [31:0]  addr);
        logic [KW-1:0] m;
        for (int b = 0; b < KW; b++)
            m[b] = key[b] ^ nonce[(b * 5 + 3) % KW] ^ addr[b % 32];
        return m;
    endfunction

    function automatic word_t ks_mix2(input logic [KW-1:0] t);
        word_t k;
        for (int i = 0; i < WW; i++)
            k[i] = t[i] ^ t[(i * 7 + 11) % KW] ^ (t[(i + 20) % KW] & t[(i + 41) % KW]);
        return k;
    endfunction
endpackage

// File: rtl/scram_ks_unit.sv
module scram_ks_unit
    import scram_mem_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              load_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [KW-1:0]     key_i,
    input  logic [KW-1:0]     nonce_i,
    output word_t             ks_o
);
    logic [KW-1:0] mid_q;
    logic [31:0]   addr_ext;

    assign addr_ext = 32'(addr_i);

    always_ff @(posedge clk_i) begin
        if (rst_i)       mid_q <= '0;
        else if (load_i) mid_q <= ks_mix1(key_i, nonce_i, addr_ext);
    end

    assign ks_o = ks_mix2(mid_q);
endmodule

// File: rtl/scram_hold_regs.sv
module scram_hold_regs
    import scram_mem_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          load_i,
    input  logic [AW-1:0] load_addr_i,
    input  word_t         load_word_i,
    input  logic          port_busy_i,
    input  word_t         ks_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o,
    output word_t         plain_o,
    output logic          commit_o,
    output word_t         commit_word_o
);
    hold_st_e      st_q;
    logic [AW-1:0] addr_q;
    word_t         plain_q;
    word_t         scram_q;
    word_t         fresh_scram;

    assign fresh_scram   = plain_q ^ ks_i;
    assign valid_o       = (st_q != HOLD_EMPTY);
    assign addr_o        = addr_q;
    assign plain_o       = plain_q;
    assign commit_o      = valid_o && !port_busy_i;
    assign commit_word_o = (st_q == HOLD_PLAIN) ? fresh_scram : scram_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q    <= HOLD_EMPTY;
            addr_q  <= '0;
            plain_q <= '0;
            scram_q <= '0;
        end else if (load_i) begin
            st_q    <= HOLD_PLAIN;
            addr_q  <= load_addr_i;
            plain_q <= load_word_i;
        end else if (commit_o) begin
            st_q <= HOLD_EMPTY;
        end else if (st_q == HOLD_PLAIN) begin
            st_q    <= HOLD_SCRAM;
            scram_q <= fresh_scram;
        end
    end
endmodule

// File: rtl/scram_mem_array.sv
module scram_mem_array
    import scram_mem_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          re_i,
    input  logic [AW-1:0] raddr_i,
    output word_t         rdata_o,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  word_t         wdata_i
);
    word_t cells [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) cells[waddr_i] <= wdata_i;
        if (re_i) rdata_o <= cells[raddr_i];
    end
endmodule

// File: rtl/scram_mem_pipe.sv
module scram_mem_pipe
    import scram_mem_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk_i,
    input  logic          rst_i,
    input  logic          req_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [3:0]    be_i,
    input  logic [31:0]   wdata_i,
    input  logic [63:0]   key_i,
    input  logic [63:0]   nonce_i,
    output logic          gnt_o,
    output logic          rvalid_o,
    output logic [31:0]   rdata_o,
    output logic [6:0]    rintg_o
);
    rmw_st_e       rmw_q;
    logic [AW-1:0] rmw_addr_q;
    logic [3:0]    rmw_be_q;
    logic [31:0]   rmw_data_q;

    logic acc, acc_rd, acc_full, acc_part, arr_re, arr_we;
    logic rd_pend_q, hit_q;
    word_t fwd_q, ks, mem_q, old_word, hold_plain, load_word, commit_word;
    logic hold_valid, hold_load;
    logic [AW-1:0] hold_addr, load_addr;
    logic [31:0] merged;

    assign gnt_o    = (rmw_q == RMW_IDLE);
    assign acc      = req_i && gnt_o;
    assign acc_rd   = acc && !we_i;
    assign acc_full = acc && we_i && (be_i == 4'hF);
    assign acc_part = acc && we_i && (be_i != 4'hF);
    assign arr_re   = acc_rd || acc_part;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rmw_q      <= RMW_IDLE;
            rmw_addr_q <= '0;
            rmw_be_q   <= '0;
            rmw_data_q <= '0;
            rd_pend_q  <= 1'b0;
            hit_q      <= 1'b0;
            fwd_q      <= '0;
        end else begin
            rd_pend_q <= acc_rd;
            if (arr_re) begin
                hit_q <= hold_valid && (hold_addr == addr_i);
                fwd_q <= hold_plain;
            end
            unique case (rmw_q)
                RMW_IDLE: if (acc_part) begin
                    rmw_q      <= RMW_MERGE;
                    rmw_addr_q <= addr_i;
                    rmw_be_q   <= be_i;
                    rmw_data_q <= wdata_i;
                end
                RMW_MERGE: rmw_q <= RMW_WRITE;
                default:   rmw_q <= RMW_IDLE;
            endcase
        end
    end

    scram_ks_unit #(.AW(AW)) u_ks (
        .clk_i(clk_i), .rst_i(rst_i), .load_i(acc), .addr_i(addr_i),
        .key_i(key_i), .nonce_i(nonce_i), .ks_o(ks)
    );

    assign old_word = hit_q ? fwd_q : (mem_q ^ ks);
    assign rvalid_o = rd_pend_q;
    assign rdata_o  = old_word[DW-1:0];
    assign rintg_o  = old_word[WW-1:DW];

    for (genvar k = 0; k < 4; k++) begin : g_merge
        assign merged[8*k +: 8] = rmw_be_q[k] ? rmw_data_q[8*k +: 8] : old_word[8*k +: 8];
    end

    assign hold_load = acc_full || (rmw_q == RMW_MERGE);
    assign load_addr = acc_full ? addr_i : rmw_addr_q;
    assign load_word = acc_full ? encode_word(wdata_i) : encode_word(merged);

    scram_hold_regs #(.AW(AW)) u_hold (
        .clk_i(clk_i), .rst_i(rst_i), .load_i(hold_load), .load_addr_i(load_addr),
        .load_word_i(load_word), .port_busy_i(arr_re), .ks_i(ks),
        .valid_o(hold_valid), .addr_o(hold_addr), .plain_o(hold_plain),
        .commit_o(arr_we), .commit_word_o(commit_word)
    );

    scram_mem_array #(.DEPTH(DEPTH)) u_arr (
        .clk_i(clk_i), .re_i(arr_re), .raddr_i(addr_i), .rdata_o(mem_q),
        .we_i(arr_we), .waddr_i(hold_addr), .wdata_i(commit_word)
    );
endmodule

// File: rtl/scram_mem_chk.sv
module scram_mem_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic       req_i,
    input logic       we_i,
    input logic [3:0] be_i,
    input logic       gnt_o,
    input logic       rvalid_o,
    input logic       arr_re,
    input logic       arr_we
);
    logic acc_part, acc_full, acc_rd;
    assign acc_part = req_i && gnt_o && we_i && (be_i != 4'hF);
    assign acc_full = req_i && gnt_o && we_i && (be_i == 4'hF);
    assign acc_rd   = req_i && gnt_o && !we_i;

    // R7
    part_stall_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        acc_part |=> !gnt_o ##1 !gnt_o ##1 gnt_o);
    // R1
    full_keeps_gnt_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        acc_full |=> gnt_o);
    // R2
    read_resp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        acc_rd |=> rvalid_o);
    // R10
    write_no_resp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && gnt_o && we_i) |=> !rvalid_o);
    // R3
    port_single_use_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({arr_re, arr_we}));
endmodule

bind scram_mem_pipe scram_mem_chk u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .req_i(req_i), .we_i(we_i), .be_i(be_i),
    .gnt_o(gnt_o), .rvalid_o(rvalid_o), .arr_re(arr_re), .arr_we(arr_we)
);

// File: tb/scram_mem_pipe_test.sv
module scram_mem_pipe_test;
    localparam int DEPTH = 64;
    localparam int AW = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_i, req_i, we_i;
    logic [AW-1:0] addr_i;
    logic [3:0] be_i;
    logic [31:0] wdata_i;
    logic gnt_o, rvalid_o;
    logic [31:0] rdata_o;
    logic [6:0] rintg_o;

    always #5 clk = ~clk;

    scram_mem_pipe #(.DEPTH(DEPTH)) uut (
        .clk_i(clk), .rst_i(rst_i), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
        .be_i(be_i), .wdata_i(wdata_i), .key_i(64'h3c5a_9e17_d024_b68f),
        .nonce_i(64'h71e2_08bd_4fa3_c659), .gnt_o(gnt_o), .rvalid_o(rvalid_o),
        .rdata_o(rdata_o), .rintg_o(rintg_o)
    );

    int vectors = 0, miscompares = 0;
    logic [31:0] ref_mem [DEPTH];
    bit known [DEPTH];
    bit ignored [DEPTH];
    bit partial_last [DEPTH];
    int stall = 0;
    bit exp_rv = 0, exp_known = 0;
    logic [31:0] exp_data;
    string exp_tag = "R2";
    bit last_wr = 0;
    logic [AW-1:0] last_wr_addr;
    string gnt_tag = "R1";

    function automatic logic [6:0] intg_of(input logic [31:0] d);
        logic [6:0] p = '0;
        for (int j = 0; j < 32; j++) p[j % 7] = p[j % 7] ^ d[j];
        return p;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit rq, input bit w, input logic [AW-1:0] a,
                       input logic [3:0] be, input logic [31:0] d);
        bit acc;
        @(negedge clk);
        check(gnt_tag, 64'(gnt_o), 64'(stall == 0));
        check(exp_rv ? exp_tag : "R10", 64'(rvalid_o), 64'(exp_rv));
        if (exp_rv && exp_known) begin
            check(exp_tag, 64'(rdata_o), 64'(exp_data));
            check("R8", 64'(rintg_o), 64'(intg_of(exp_data)));
        end
        req_i = rq; we_i = w; addr_i = a; be_i = be; wdata_i = d;
        acc = rq && (stall == 0);
        gnt_tag = "R1";
        if (stall > 0) begin
            gnt_tag = "R7";
            stall--;
            if (rq && w) ignored[a] = 1;
        end
        exp_rv = acc && !w;
        if (acc && !w) begin
            exp_known = known[a];
            exp_data  = ref_mem[a];
            if (last_wr && last_wr_addr == a) exp_tag = "R4";
            else if (ignored[a])              exp_tag = "R11";
            else if (partial_last[a])         exp_tag = "R6";
            else                              exp_tag = "R5";
        end
        if (acc && w) begin
            for (int k = 0; k < 4; k++)
                if (be[k]) ref_mem[a][8*k +: 8] = d[8*k +: 8];
            if (be != 4'hF) begin
                stall = 2;
                gnt_tag = "R7";
                partial_last[a] = 1;
            end else begin
                known[a] = 1;
                partial_last[a] = 0;
            end
        end
        last_wr = acc && w;
        last_wr_addr = a;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        rst_i = 1; req_i = 0; we_i = 0; addr_i = '0; be_i = '0; wdata_i = '0;
        for (int i = 0; i < DEPTH; i++) begin
            known[i] = 0; ignored[i] = 0; partial_last[i] = 0; ref_mem[i] = '0;
        end
        repeat (3) begin
            @(negedge clk);
            check("R9", 64'(gnt_o), 64'd1);
            check("R9", 64'(rvalid_o), 64'd0);
        end
        rst_i = 0;
        // R1: back-to-back full writes fill the memory
        for (int i = 0; i < DEPTH; i++) cyc(1, 1, AW'(i), 4'hF, 32'h1000_0000 + 32'(i * 3));
        // R2: reads of every word
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, AW'(i), 4'h0, '0);
        // R3/R4: alternating write/read, same address
        for (int i = 0; i < 8; i++) begin
            cyc(1, 1, AW'(5), 4'hF, 32'hA5A5_0000 + 32'(i));
            cyc(1, 0, AW'(5), 4'h0, '0);
        end
        // R3: alternating, different addresses
        for (int i = 0; i < 8; i++) begin
            cyc(1, 1, AW'(10 + i), 4'hF, 32'h5A00_0000 ^ 32'(i * 77));
            cyc(1, 0, AW'(9 + i), 4'h0, '0);
        end
        // R5: write then a run of reads elsewhere, then read it back
        cyc(1, 1, AW'(30), 4'hF, 32'hDEAD_BEEF);
        for (int i = 0; i < 5; i++) cyc(1, 0, AW'(i), 4'h0, '0);
        cyc(1, 0, AW'(30), 4'h0, '0);
        cyc(0, 0, '0, 4'h0, '0);
        // R6/R7: partial writes, incl. zero mask and one behind a pending full write
        cyc(1, 1, AW'(40), 4'hF, 32'h1122_3344);
        cyc(1, 1, AW'(40), 4'b0101, 32'hAABB_CCDD);
        cyc(1, 0, AW'(40), 4'h0, '0);
        cyc(1, 0, AW'(40), 4'h0, '0);
        cyc(1, 0, AW'(40), 4'h0, '0);
        cyc(1, 1, AW'(41), 4'b1000, 32'hFF00_0000);
        cyc(1, 1, AW'(42), 4'hF, 32'h0BAD_F00D);   // R11: ignored during stall
        cyc(1, 1, AW'(43), 4'hF, 32'h0BAD_F00D);   // R11: ignored during stall
        cyc(1, 0, AW'(41), 4'h0, '0);
        cyc(1, 1, AW'(44), 4'h0, 32'hFFFF_FFFF);
        cyc(0, 0, '0, 4'h0, '0);
        cyc(0, 0, '0, 4'h0, '0);
        cyc(1, 0, AW'(44), 4'h0, '0);
        cyc(1, 0, AW'(42), 4'h0, '0);
        cyc(1, 0, AW'(43), 4'h0, '0);
        // random traffic over four addresses
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 9);
            logic [3:0] be = (r < 3) ? 4'($urandom_range(0, 14)) : 4'hF;
            cyc($urandom_range(0, 7) != 0, r < 5, AW'($urandom_range(0, 3)), be, $urandom);
        end
        for (int i = 0; i < DEPTH; i++) cyc(1, 0, AW'(i), 4'h0, '0);
        cyc(0, 0, '0, 4'h0, '0);
        cyc(0, 0, '0, 4'h0, '0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule